// File: doc/BRIEF.md
# Pipelined Event Counter

This block counts clock cycles in which its enable input is high, at one increment per cycle, at clock rates where a single full-width adder cannot close timing. The count is cut into narrow segments. Each segment increments on its own short adder, and the carry out of a segment is registered before it reaches the next segment up. Lower segments then pass through delay lines of graded depth. The assembled word is therefore a coherent snapshot of the count as it stood a fixed number of cycles earlier.

A consumer gates the enable for a measurement window and drops it at the end. It then waits for the settled flag before it takes the count. The flag tells the consumer that every enabled cycle has reached the output. A synchronous clear restarts the count and throws away any increment still travelling through the pipeline.

Top module: `pipe_event_counter`

## Requirements
- R1: The count output is CNT_W bits wide (default 31) and holds a plain binary value. The count is cut into NSEG = ceil(CNT_W/SEG_W) segments (default SEG_W = 8, so NSEG = 4). The highest segment takes the leftover bits.
- R2: Each rising clock edge at which en_i is 1 and clr_i is 0 adds exactly one to the count. Any other edge adds nothing.
- R3: After clock edge n, count_o equals the number of counting edges among edges 1 to n-NSEG. Only edges after the most recent clear or reset are included. The latency is therefore NSEG cycles.
- R4: count_o never shows a partly carried value. When a segment rolls over, the output steps by 0 or 1 per cycle, and the step of 1 is taken modulo 2^CNT_W.
- R5: The count wraps modulo 2^CNT_W, including when CNT_W is not a multiple of SEG_W.
- R6: An edge with clr_i = 1 takes priority over en_i. After that edge, count_o is 0 and settled_o is 1. Every increment that was still travelling through the pipeline is discarded.
- R7: After any edge at which en_i is 1 and clr_i is 0, settled_o is 0.
- R8: After edge n, settled_o is 1 exactly when none of edges n-NSEG+1 to n was a counting edge. While settled_o is 1 and no clear arrives, count_o does not change.
- R9: While rst_ni is 0, count_o is 0 and settled_o is 1. Both take these values without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the count and of the pipeline |
| en_i | input | 1 | Count enable, sampled on each rising edge |
| count_o | output | CNT_W | Delayed coherent count |
| settled_o | output | 1 | High when count_o includes every enabled cycle |

## Verification
A counting edge shows up in count_o NSEG edges later: four edges for the default build, and three for a second instance with CNT_W = 10 and SEG_W = 4. The same edge pulls settled_o low at once. settled_o returns high NSEG edges after the last counting edge, and a clear takes effect at the very next edge. For every edge, the bench works out the expected count and flag from a reference counter with a delayed history. It queues them before the edge and compares them one time unit after it. Stimulus includes single pulses, random enable patterns, clears that arrive while counting, and a long run that crosses the 256 and 65536 boundaries and wraps the small instance many times.

// File: rtl/pec_pkg.sv
package pec_pkg;

  function automatic int seg_count(input int total_w, input int seg_w);
    return (total_w + seg_w - 1) / seg_w;
  endfunction

  function automatic int seg_width(input int total_w, input int seg_w, input int idx);
    int nseg;
    nseg = seg_count(total_w, seg_w);
    if (idx == nseg - 1) return total_w - seg_w * (nseg - 1);
    return seg_w;
  endfunction

endpackage

// File: rtl/pec_segment.sv
module pec_segment #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         full_o
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         val_en;

  always_comb begin
    val_en = clr_i | inc_i;
    if (clr_i) val_d = '0;
    else       val_d = val_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign val_o  = val_q;
  assign full_o = &val_q;

endmodule

// File: rtl/pec_delay.sv
module pec_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  if (D == 0) begin : g_pass
    assign out_o = in_i;
  end else begin : g_line
    logic [W-1:0] stg_q [D];
    logic [W-1:0] stg_d [D];

    always_comb begin
      for (int i = 0; i < D; i++) begin
        if (clr_i)       stg_d[i] = '0;
        else if (i == 0) stg_d[i] = in_i;
        else             stg_d[i] = stg_q[i-1];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < D; i++) stg_q[i] <= '0;
      end else begin
        for (int i = 0; i < D; i++) stg_q[i] <= stg_d[i];
      end
    end

    assign out_o = stg_q[D-1];
  end

endmodule

// File: rtl/pec_settle.sv
module pec_settle #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic settled_o
);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  always_comb begin
    if (clr_i) hist_d = '0;
    else if (DEPTH == 1) hist_d = DEPTH'(en_i);
    else hist_d = {hist_q[DEPTH-2:0], en_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

  assign settled_o = ~|hist_q;

endmodule

// File: rtl/pipe_event_counter.sv
module pipe_event_counter #(
  parameter int CNT_W = 31,
  parameter int SEG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             settled_o
);

  localparam int NSEG = pec_pkg::seg_count(CNT_W, SEG_W);

  logic [NSEG-1:0]  inc;
  logic [NSEG-1:0]  full;
  logic [CNT_W-1:0] aligned;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign inc[0] = en_i & ~clr_i;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int W  = pec_pkg::seg_width(CNT_W, SEG_W, k);
    localparam int LO = k * SEG_W;
    logic [W-1:0] raw;

    pec_segment #(.W(W)) seg_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .inc_i  (inc[k]),
      .val_o  (raw),
      .full_o (full[k])
    );

    pec_delay #(.W(W), .D(NSEG - 1 - k)) dly_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .in_i   (raw),
      .out_o  (aligned[LO +: W])
    );

    if (k < NSEG - 1) begin : g_carry
      logic cy_q;
      logic cy_d;

      always_comb begin
        if (clr_i) cy_d = 1'b0;
        else       cy_d = inc[k] & full[k];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cy_q <= 1'b0;
        else         cy_q <= cy_d;
      end

      assign inc[k+1] = cy_q;
    end else begin : g_top
      logic top_full_unused;
      assign top_full_unused = full[k];
    end
  end

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = aligned;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  pec_settle #(.DEPTH(NSEG)) settle_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .en_i      (en_i),
    .settled_o (settled_o)
  );

endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int CNT_W = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             settled_o
);

  // R6: clear empties the pipeline at the next edge
  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0) && settled_o);

  // R7: a counting edge pulls the settled flag down
  a_r7_busy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> !settled_o);

  // R8: the count holds still once settled
  a_r8_settled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_o && !clr_i) |=> $stable(count_o));

  // R4: no partial carries, step of 0 or 1
  a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((count_o - $past(count_o)) <= CNT_W'(1)));

endmodule

bind pipe_event_counter pec_checker #(.CNT_W(CNT_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .en_i      (en_i),
  .count_o   (count_o),
  .settled_o (settled_o)
);

// File: tb/pipe_event_counter_tb_top.sv
module pipe_event_counter_tb_top;

  localparam int LB = 4;  // latency of default build
  localparam int LS = 3;  // latency of small build (10 bits, 4-bit segments)

  logic clk = 1'b0;
  logic rst_n;
  logic clr;
  logic en;
  logic [30:0] cnt_b;
  logic [9:0]  cnt_s;
  logic        set_b, set_s;

  always #10 clk = ~clk;

  pipe_event_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en),
    .count_o(cnt_b), .settled_o(set_b));

  pipe_event_counter #(.CNT_W(10), .SEG_W(4)) dut_s_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en),
    .count_o(cnt_s), .settled_o(set_s));

  typedef struct {
    logic [30:0] cb;
    logic [9:0]  cs;
    logic        sb;
    logic        ss;
    string       tc;
    string       ts;
  } exp_t;

  exp_t sbq[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  string ctag = "R3";
  string stag = "R8";

  logic [31:0] ref_cnt;
  logic [31:0] rh [8];
  logic        eh [8];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: sets inputs for the next edge and queues the outcome it must produce
  task automatic step(input logic e, input logic c);
    exp_t x;
    @(negedge clk);
    en  = e;
    clr = c;
    if (c) begin
      ref_cnt = '0;
      for (int i = 0; i < 8; i++) begin rh[i] = '0; eh[i] = 1'b0; end
    end else begin
      ref_cnt = ref_cnt + 32'(e);
      for (int i = 7; i > 0; i--) begin rh[i] = rh[i-1]; eh[i] = eh[i-1]; end
      rh[0] = ref_cnt;
      eh[0] = e;
    end
    x.cb = rh[LB][30:0];
    x.cs = rh[LS][9:0];
    x.sb = !(eh[0] | eh[1] | eh[2] | eh[3]);
    x.ss = !(eh[0] | eh[1] | eh[2]);
    x.tc = ctag;
    x.ts = stag;
    sbq.push_back(x);
  endtask

  // monitor: compares one time unit after each edge
  always begin
    exp_t x;
    @(posedge clk);
    #1;
    if (sbq.size() > 0) begin
      x = sbq.pop_front();
      check({x.tc, " count big"},   32'(cnt_b), 32'(x.cb));
      check({x.tc, " count small"}, 32'(cnt_s), 32'(x.cs));
      check({x.ts, " settled big"},   32'(set_b), 32'(x.sb));
      check({x.ts, " settled small"}, 32'(set_s), 32'(x.ss));
    end
  end

  initial begin
    #(190000 * 20);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clr = 1'b0;
    en  = 1'b0;
    ref_cnt = '0;
    for (int i = 0; i < 8; i++) begin rh[i] = '0; eh[i] = 1'b0; end
    #5;
    // R9: asynchronous reset values
    check("R9 count big",  32'(cnt_b), 32'd0);
    check("R9 count small", 32'(cnt_s), 32'd0);
    check("R9 settled big", 32'(set_b), 32'd1);
    check("R9 settled small", 32'(set_s), 32'd1);
    // R1: output width
    check("R1 width", 32'($bits(cnt_b)), 32'd31);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // idle: nothing counted, flag stays up
    ctag = "R2"; stag = "R8";
    repeat (6) step(1'b0, 1'b0);

    // single pulse: latency and settle timing
    ctag = "R3"; stag = "R7";
    step(1'b1, 1'b0);
    stag = "R8";
    repeat (8) step(1'b0, 1'b0);

    // random enable patterns
    ctag = "R2"; stag = "R8";
    for (int i = 0; i < 2000; i++) step(1'($urandom_range(0, 1)), 1'b0);
    repeat (6) step(1'b0, 1'b0);

    // clear while enabled discards in-flight increments
    ctag = "R6"; stag = "R6";
    repeat (3) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    repeat (2) step(1'b0, 1'b0);

    // long burst across segment rollovers; small build wraps
    ctag = "R4"; stag = "R7";
    for (int i = 0; i < 66000; i++) step(1'b1, 1'b0);
    ctag = "R5"; stag = "R8";
    repeat (6) step(1'b0, 1'b0);
    for (int i = 0; i < 3000; i++) step(1'($urandom_range(0, 3) != 0), 1'b0);

    // random pattern with occasional clears
    ctag = "R6"; stag = "R6";
    for (int i = 0; i < 1500; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 99) == 0));
    ctag = "R3"; stag = "R8";
    repeat (8) step(1'b0, 1'b0);

    @(posedge clk);
    #2;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule